// File: doc/BRIEF.md
# Accumulator ALU with Flag Byte

This block performs the arithmetic and logic step of an accumulator-based 8-bit processor. On each cycle with `exec_i` high it combines the accumulator value presented by the datapath with a second operand. The second operand is either a register value or an immediate byte. The operation code selects add, add-with-carry, subtract, subtract-with-borrow, AND, XOR, OR, compare or rotate-left-circular. At the next rising clock edge the block registers the new accumulator value and a packed flag byte. The flag byte holds sign, zero, auxiliary carry, parity and carry.

The carry used by the carry-in and borrow-in variants is the carry bit of the flag byte held inside the block, so chained multi-byte arithmetic needs no extra wiring. A combinational condition output tells the sequencer whether a conditional branch selected by `cond_i` would be taken, given the flags currently held. Instruction decode, memory access and the program counter live elsewhere.

Top module: `acc_alu`

## Requirements
- R1: While `rst_ni` is low and after it is released, `acc_o` is 0 and `flags_o` is 0x00.
- R2: Op code 0 (add) and op code 1 (add-with-carry) register `acc_i + opnd_i + cin` modulo 256. For op code 1, cin is the held carry flag; for op code 0 it is 0. The carry flag (bit 0) is the carry out of bit 7. The auxiliary carry flag (bit 4) is the carry out of bit 3.
- R3: Op code 2 (subtract) and op code 3 (subtract-with-borrow) register `acc_i - opnd_i - bin` modulo 256. For op code 3, bin is the held carry flag; for op code 2 it is 0. The carry flag (bit 0) is 1 when `opnd_i + bin` exceeds `acc_i` as unsigned values. The auxiliary carry flag (bit 4) is 1 when the low nibble of the operand plus bin exceeds the low nibble of the accumulator.
- R4: Op code 7 (compare) sets all five flags exactly as op code 2 would. It registers `acc_i` unchanged on `acc_o`. Comparing equal values gives Z=1 and CY=0.
- R5: Op code 4 registers AND, op code 5 registers XOR, and op code 6 registers OR of the two inputs. AND sets AC=1 and CY=0. XOR and OR set AC=0 and CY=0.
- R6: For op codes 0 to 7, the sign flag (bit 7) equals bit 7 of the computed result. The zero flag (bit 6) is 1 when that result is zero. The parity flag (bit 2) is 1 when that result has an even number of ones. For compare, the computed result is the difference.
- R7: Op code 8 (rotate-left-circular) registers `{acc_i[6:0], acc_i[7]}` and copies `acc_i[7]` into the carry flag. Sign, zero, auxiliary carry and parity keep their previous values.
- R8: Bits 5, 3 and 1 of `flags_o` always read 0.
- R9: With `exec_i` low, or with a reserved op code (9 to 15), `acc_o` and `flags_o` keep their values.
- R10: `take_o` evaluates `cond_i` against the held flags: 0 when Z=0, 1 when Z=1, 2 when CY=0, 3 when CY=1, 4 when P=0, 5 when P=1, 6 when S=0, and 7 when S=1.
- R11: Results of an operation sampled at a rising edge appear on `acc_o` and `flags_o` directly after that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Perform the operation on this edge |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand (register or immediate) |
| cond_i | input | 3 | Branch condition selector |
| acc_o | output | 8 | Registered accumulator result |
| flags_o | output | 8 | Registered flag byte: S=7, Z=6, AC=4, P=2, CY=0 |
| take_o | output | 1 | Selected condition holds on the current flags |

## Verification
The accumulator and flag results of an operation are due one clock after the rising edge that samples `exec_i`. The bench therefore drives inputs on a falling edge and compares both outputs on the following falling edge, against a reference model that tracks the held carry between operations. `take_o` depends only on the registered flags and `cond_i`. It is checked for all eight selectors by stepping `cond_i` in the half-period after the result settles, before the next rising edge. Idle cycles and reserved op codes are checked by confirming that both outputs are unchanged one cycle later.

// File: rtl/alu_pkg.sv
package alu_pkg;
   // operation codes
   localparam logic [3:0] OP_ADD = 4'd0;
   localparam logic [3:0] OP_ADC = 4'd1;
   localparam logic [3:0] OP_SUB = 4'd2;
   localparam logic [3:0] OP_SBB = 4'd3;
   localparam logic [3:0] OP_AND = 4'd4;
   localparam logic [3:0] OP_XOR = 4'd5;
   localparam logic [3:0] OP_OR  = 4'd6;
   localparam logic [3:0] OP_CMP = 4'd7;
   localparam logic [3:0] OP_RLC = 4'd8;

   // flag byte positions
   localparam int FLG_S  = 7;
   localparam int FLG_Z  = 6;
   localparam int FLG_AC = 4;
   localparam int FLG_P  = 2;
   localparam int FLG_CY = 0;
   localparam int FLG_W  = 8;

   // branch condition selectors
   localparam logic [2:0] CND_NZ  = 3'd0;
   localparam logic [2:0] CND_Z   = 3'd1;
   localparam logic [2:0] CND_NC  = 3'd2;
   localparam logic [2:0] CND_C   = 3'd3;
   localparam logic [2:0] CND_PO  = 3'd4;
   localparam logic [2:0] CND_PE  = 3'd5;
   localparam logic [2:0] CND_POS = 3'd6;
   localparam logic [2:0] CND_NEG = 3'd7;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cy_o,
   output logic              ac_o
);
   localparam int NIB_W = 4;

   logic [DATA_W-1:0] b_eff;
   logic              c_eff;
   logic [DATA_W:0]   full_sum;
   logic [NIB_W:0]    low_sum;

   // subtraction as a + ~b + ~borrow; carry out inverted gives borrow
   assign b_eff    = sub_i ? ~b_i : b_i;
   assign c_eff    = sub_i ? ~cin_i : cin_i;
   assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
   assign low_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                   + {{NIB_W{1'b0}}, c_eff};

   assign res_o = full_sum[DATA_W-1:0];
   assign cy_o  = full_sum[DATA_W] ^ sub_i;
   assign ac_o  = low_sum[NIB_W] ^ sub_i;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int DATA_W  = 8,
   parameter bit HAS_ROT = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [1:0]        sel_i,
   output logic [DATA_W-1:0] res_o,
   output logic [DATA_W-1:0] rot_o
);
   always_comb begin
      case (sel_i)
         2'd0:    res_o = a_i & b_i;
         2'd1:    res_o = a_i ^ b_i;
         default: res_o = a_i | b_i;
      endcase
   end

   generate
      if (HAS_ROT) begin : g_rot
         assign rot_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
      end else begin : g_no_rot
         assign rot_o = a_i;
      end
   endgenerate
endmodule

// File: rtl/alu_cond.sv
module alu_cond
   import alu_pkg::*;
(
   input  logic [FLG_W-1:0] flags_i,
   input  logic [2:0]       cond_i,
   output logic             take_o
);
   always_comb begin
      case (cond_i)
         CND_NZ:  take_o = ~flags_i[FLG_Z];
         CND_Z:   take_o =  flags_i[FLG_Z];
         CND_NC:  take_o = ~flags_i[FLG_CY];
         CND_C:   take_o =  flags_i[FLG_CY];
         CND_PO:  take_o = ~flags_i[FLG_P];
         CND_PE:  take_o =  flags_i[FLG_P];
         CND_POS: take_o = ~flags_i[FLG_S];
         default: take_o =  flags_i[FLG_S];
      endcase
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit HAS_ROT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              exec_i,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [2:0]        cond_i,
   output logic [DATA_W-1:0] acc_o,
   output logic [FLG_W-1:0]  flags_o,
   output logic              take_o
);
   generate
      if (DATA_W < 5) begin : g_bad_width
         $error("acc_alu: DATA_W must be at least 5");
      end
   endgenerate

   logic [DATA_W-1:0] acc_q, nxt_acc;
   logic [FLG_W-1:0]  flg_q, nxt_flg;
   logic              upd;

   logic              is_sub, use_cin;
   logic [DATA_W-1:0] as_res, lg_res, rot_res;
   logic              as_cy, as_ac;

   function automatic logic [FLG_W-1:0] pack_flags(input logic [DATA_W-1:0] r,
                                                   input logic ac, input logic cy);
      logic [FLG_W-1:0] f;
      f         = '0;
      f[FLG_S]  = r[DATA_W-1];
      f[FLG_Z]  = ~|r;
      f[FLG_AC] = ac;
      f[FLG_P]  = ~^r;
      f[FLG_CY] = cy;
      return f;
   endfunction

   assign is_sub  = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
   assign use_cin = (op_i == OP_ADC) || (op_i == OP_SBB);

   alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .cin_i (use_cin & flg_q[FLG_CY]),
      .sub_i (is_sub),
      .res_o (as_res),
      .cy_o  (as_cy),
      .ac_o  (as_ac)
   );

   alu_logic #(.DATA_W(DATA_W), .HAS_ROT(HAS_ROT)) u_logic (
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .sel_i (op_i[1:0]),
      .res_o (lg_res),
      .rot_o (rot_res)
   );

   alu_cond u_cond (
      .flags_i (flg_q),
      .cond_i  (cond_i),
      .take_o  (take_o)
   );

   always_comb begin
      nxt_acc = acc_q;
      nxt_flg = flg_q;
      upd     = 1'b1;
      case (op_i)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
            nxt_acc = as_res;
            nxt_flg = pack_flags(as_res, as_ac, as_cy);
         end
         OP_CMP: begin
            nxt_acc = acc_i;
            nxt_flg = pack_flags(as_res, as_ac, as_cy);
         end
         OP_AND, OP_XOR, OP_OR: begin
            nxt_acc = lg_res;
            nxt_flg = pack_flags(lg_res, op_i == OP_AND, 1'b0);
         end
         OP_RLC: begin
            if (HAS_ROT) begin
               nxt_acc         = rot_res;
               nxt_flg[FLG_CY] = acc_i[DATA_W-1];
            end else begin
               upd = 1'b0;
            end
         end
         default: upd = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
         flg_q <= '0;
      end else if (exec_i && upd) begin
         acc_q <= nxt_acc;
         flg_q <= nxt_flg;
      end
   end

   assign acc_o   = acc_q;
   assign flags_o = flg_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit HAS_ROT = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              exec_i,
   input logic [3:0]        op_i,
   input logic [DATA_W-1:0] acc_i,
   input logic [DATA_W-1:0] opnd_i,
   input logic [DATA_W-1:0] acc_o,
   input logic [FLG_W-1:0]  flags_o
);
   a_r8_spare_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && (flags_o[1] == 1'b0));

   a_r4_cmp_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_i && (op_i == OP_CMP) |=> acc_o == $past(acc_i));

   a_r4_cmp_equal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_i && (op_i == OP_CMP) && (acc_i == opnd_i)
      |=> flags_o[FLG_Z] && !flags_o[FLG_CY]);

   a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !exec_i || (op_i > OP_RLC) |=> $stable(acc_o) && $stable(flags_o));

   a_r6_zero_tracks_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_i && (op_i <= OP_OR) |=> flags_o[FLG_Z] == (acc_o == '0));

   a_r6_parity_tracks_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_i && (op_i <= OP_OR) |=> flags_o[FLG_P] == ~^acc_o);

   a_r6_sign_tracks_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_i && (op_i <= OP_OR) |=> flags_o[FLG_S] == acc_o[DATA_W-1]);

   a_r5_and_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_i && (op_i == OP_AND) |=> flags_o[FLG_AC] && !flags_o[FLG_CY]);

   generate
      if (HAS_ROT) begin : g_rot_chk
         a_r7_rlc_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
            exec_i && (op_i == OP_RLC)
            |=> (flags_o[FLG_CY] == acc_o[0]) && (acc_o[0] == $past(acc_i[DATA_W-1])));
      end
   endgenerate
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .HAS_ROT(HAS_ROT)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .exec_i  (exec_i),
   .op_i    (op_i),
   .acc_i   (acc_i),
   .opnd_i  (opnd_i),
   .acc_o   (acc_o),
   .flags_o (flags_o)
);

// File: tb/tb_acc_alu.sv
`timescale 1ns/100ps
module tb_acc_alu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exec = 1'b0;
   logic [3:0] op = 4'd0;
   logic [7:0] acc_in = 8'd0;
   logic [7:0] opnd = 8'd0;
   logic [2:0] cond = 3'd0;
   logic [7:0] acc_out;
   logic [7:0] flags;
   logic       take;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] exp_acc = 8'd0;
   logic [7:0] exp_flg = 8'd0;

   always #5 clk = ~clk;

   acc_alu dut (
      .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .op_i(op),
      .acc_i(acc_in), .opnd_i(opnd), .cond_i(cond),
      .acc_o(acc_out), .flags_o(flags), .take_o(take)
   );

   function automatic logic [7:0] mkf(input logic [7:0] r, input logic ac, input logic cy);
      logic [7:0] f = 8'h00;
      f[7] = r[7];
      f[6] = (r == 8'h00);
      f[4] = ac;
      f[2] = ~^r;
      f[0] = cy;
      return f;
   endfunction

   // returns {acc, flags}
   function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] f,
                                         input logic [7:0] pa);
      int c, s, lo;
      logic [7:0] r;
      c = (o == 4'd1 || o == 4'd3) ? int'(f[0]) : 0;
      case (o)
         4'd0, 4'd1: begin
            s  = int'(a) + int'(b) + c;
            lo = int'(a[3:0]) + int'(b[3:0]) + c;
            r  = s[7:0];
            return {r, mkf(r, lo > 15, s > 255)};
         end
         4'd2, 4'd3, 4'd7: begin
            s = int'(a) - int'(b) - c;
            r = s[7:0];
            return {(o == 4'd7) ? a : r,
                    mkf(r, (int'(b[3:0]) + c) > int'(a[3:0]), (int'(b) + c) > int'(a))};
         end
         4'd4: return {a & b, mkf(a & b, 1'b1, 1'b0)};
         4'd5: return {a ^ b, mkf(a ^ b, 1'b0, 1'b0)};
         4'd6: return {a | b, mkf(a | b, 1'b0, 1'b0)};
         4'd8: return {{a[6:0], a[7]}, {f[7:1], a[7]}};
         default: return {pa, f};
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] o);
      case (o)
         4'd0, 4'd1: return "R2";
         4'd2, 4'd3: return "R3";
         4'd7: return "R4";
         4'd4, 4'd5, 4'd6: return "R5";
         4'd8: return "R7";
         default: return "R9";
      endcase
   endfunction

   function automatic logic cond_ref(input logic [2:0] c, input logic [7:0] f);
      case (c)
         3'd0: return ~f[6];
         3'd1: return f[6];
         3'd2: return ~f[0];
         3'd3: return f[0];
         3'd4: return ~f[2];
         3'd5: return f[2];
         3'd6: return ~f[7];
         default: return f[7];
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic check_outputs(input string tag);
      check({tag, "/R11 acc"}, acc_out, exp_acc);
      check({tag, "/R6 flags"}, flags, exp_flg);
      check("R8 spare flag bits", flags & 8'h2A, 8'h00);
      for (int c = 0; c < 8; c++) begin
         cond = 3'(c);
         #0.5;
         check("R10 take", {7'd0, take}, {7'd0, cond_ref(3'(c), exp_flg)});
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
      logic [15:0] m;
      @(negedge clk);
      op = o; acc_in = a; opnd = b; exec = 1'b1;
      m = model(o, a, b, exp_flg, exp_acc);
      @(negedge clk);
      exec = 1'b0;
      exp_acc = m[15:8];
      exp_flg = m[7:0];
      check_outputs(tag_of(o));
   endtask

   task automatic idle_cycle(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      op = o; acc_in = a; opnd = b; exec = 1'b0;
      @(negedge clk);
      check_outputs("R9 idle");
   endtask

   initial begin : watchdog
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd5171));
      repeat (3) @(negedge clk);
      check("R1 reset acc", acc_out, 8'h00);
      check("R1 reset flags", flags, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", flags, 8'h00);

      apply(4'd0, 8'hFF, 8'h01);   // R2 wrap: zero, carry, aux carry
      apply(4'd1, 8'h0E, 8'h01);   // R2 carry-in used
      apply(4'd1, 8'h7F, 8'h00);   // R2 carry now clear
      apply(4'd2, 8'h00, 8'h01);   // R3 borrow on 0-1
      apply(4'd3, 8'h10, 8'h0F);   // R3 borrow-in used
      apply(4'd3, 8'h05, 8'h05);   // R3 no borrow in, zero
      apply(4'd7, 8'h3C, 8'h3C);   // R4 compare equal -> Z=1
      apply(4'd7, 8'h01, 8'h02);   // R4 compare less -> borrow
      apply(4'd4, 8'hF0, 8'h3C);   // R5 AND
      apply(4'd5, 8'hAA, 8'hAA);   // R5 XOR to zero
      apply(4'd6, 8'h80, 8'h01);   // R5 OR negative
      apply(4'd8, 8'h80, 8'h00);   // R7 bit 7 to bit 0 and carry
      apply(4'd8, 8'h41, 8'h00);   // R7 carry cleared
      apply(4'd12, 8'h12, 8'h34);  // R9 reserved op
      idle_cycle(4'd0, 8'hFF, 8'hFF);

      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 7) == 0)
            idle_cycle(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom));
         else
            apply(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule